// File: doc/BRIEF.md
# Ordered Processor Store Buffer

This block sits between a core's execute stage and a memory or cache write port. It holds the core's stores so that execution continues without waiting for each write to finish. Each store carries an address, a data word and byte enables. Entries leave the buffer for memory strictly in arrival order through a valid/ready write interface, and back-pressure from memory stalls retirement without reordering or losing anything.

A vector of synchronizing event inputs forces the buffer to empty itself completely. Examples are an exception or interrupt, a serializing instruction, an I/O access, a locked operation, a fence and a bus-initialization event. While a drain is in progress the buffer refuses new stores. A one-cycle completion pulse and a level empty flag let the core hold off until every older write has reached memory.

A combinational lookup port lets a younger load check the pending stores. It returns the data of the youngest store to the same address when that store covers every byte. It raises a conflict flag when that store covers only some of the bytes. DEPTH must be a power of two.

Top module: `stbuf_ordered`

## Requirements
- R1: When the buffer is not full and no drain is in progress, `st_ready` is high. A store presented with `st_valid` in such a cycle is accepted and later appears on the memory port.
- R2: Memory receives exactly the accepted stores, with the same address, data and byte enables, in the order they were accepted, and nothing else.
- R3: While `mem_valid` is high and `mem_ready` is low, the memory port outputs hold their values on the next cycle and no entry is dropped.
- R4: With DEPTH entries held, `st_ready` is low unless `mem_ready` is high in that same cycle. In that case a push and a pop take place together.
- R5: Any set bit of `sync_ev` starts a drain from the next cycle, and `st_ready` stays low until the drain has finished. The bit meanings are: bit 0 exception or interrupt, bit 1 serializing instruction, bit 2 I/O access, bit 3 locked operation, bit 4 store or full fence, bit 5 bus initialization.
- R6: `drain_done` pulses only in a cycle where a drain is active and the buffer is empty, after memory has accepted every store taken before the request. The drain ends on the following cycle. A request made on an empty buffer completes on the next cycle.
- R7: `buf_empty` is high exactly when no entries are held, and `mem_valid` is its inverse.
- R8: When the youngest held store whose address equals `ld_addr` has all byte enables set, `ld_hit` is high and `ld_data` carries that store's data.
- R9: When the youngest matching store has only some byte enables set, `ld_conflict` is high and `ld_hit` is low.
- R10: When no held store matches `ld_addr`, `ld_hit` and `ld_conflict` are both low.
- R11: After reset the buffer is empty, `mem_valid` and `drain_done` are low and `st_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered by the core |
| st_ready | output | 1 | Store can be accepted this cycle |
| st_addr | input | ADDR_W | Store address |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| mem_valid | output | 1 | Oldest entry presented to memory |
| mem_ready | input | 1 | Memory accepts the presented entry |
| mem_addr | output | ADDR_W | Address of oldest entry |
| mem_data | output | DATA_W | Data of oldest entry |
| mem_be | output | DATA_W/8 | Byte enables of oldest entry |
| sync_ev | input | 6 | Synchronizing events that force a full drain |
| drain_done | output | 1 | One-cycle pulse when a drain has completed |
| buf_empty | output | 1 | No entries held |
| ld_addr | input | ADDR_W | Load lookup address |
| ld_hit | output | 1 | Fully covering youngest match found |
| ld_conflict | output | 1 | Youngest match covers only part of the word |
| ld_data | output | DATA_W | Forwarded data when `ld_hit` is high |

## Verification
Suppose the ring pointers or the occupancy count go wrong. Then memory receives a store out of order, a stale store or a duplicate, and the scoreboard catches this on the very handshake where it occurs. A drain controller that releases too early shows up as a `drain_done` pulse while `buf_empty` is still low, in that same cycle. A drain that never ends leaves `st_ready` low for good, which shows one cycle after the drain should have completed. An error in the age ordering of the lookup appears at once as the wrong forwarded word, or as a missing conflict flag, while the buffer is held full.

// File: rtl/stbuf_pkg.sv
package stbuf_pkg;
  localparam int unsigned NUM_SYNC_EV = 6;

  // Bit positions of the synchronizing event vector
  typedef enum int unsigned {
    EV_EXC_IRQ   = 0,
    EV_SERIALIZE = 1,
    EV_IO        = 2,
    EV_LOCKED    = 3,
    EV_FENCE     = 4,
    EV_BUS_INIT  = 5
  } sync_ev_e;
endpackage

// File: rtl/stbuf_drain_ctl.sv
module stbuf_drain_ctl #(
  parameter int unsigned NUM_EV = stbuf_pkg::NUM_SYNC_EV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_EV-1:0] sync_ev,
  input  logic              empty,
  output logic              active,
  output logic              done
);
  logic active_q, active_d;

  // Sticky request: held until the buffer has been seen empty while active
  always_comb begin
    active_d = (|sync_ev) | (active_q & ~empty);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) active_q <= 1'b0;
    else        active_q <= active_d;
  end

  assign active = active_q;
  assign done   = active_q & empty;
endmodule

// File: rtl/stbuf_ring.sv
module stbuf_ring #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic              pop,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  output logic [ADDR_W-1:0] slot_addr [DEPTH],
  output logic [DATA_W-1:0] slot_data [DEPTH],
  output logic [BE_W-1:0]   slot_be   [DEPTH],
  output logic [PTR_W-1:0]  head,
  output logic [PTR_W:0]    count
);
  logic [PTR_W-1:0] head_q, head_d, tail_q, tail_d;
  logic [PTR_W:0]   cnt_q, cnt_d;

  always_comb begin
    head_d = head_q;
    tail_d = tail_q;
    cnt_d  = cnt_q;
    if (push) tail_d = tail_q + 1'b1;
    if (pop)  head_d = head_q + 1'b1;
    case ({push, pop})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      head_q <= head_d;
      tail_q <= tail_d;
      cnt_q  <= cnt_d;
    end
  end

  // Payload storage: no reset, written under the push enable
  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    logic wen;
    assign wen = push && (tail_q == PTR_W'(g));
    always_ff @(posedge clk) begin
      if (wen) begin
        slot_addr[g] <= in_addr;
        slot_data[g] <= in_data;
        slot_be[g]   <= in_be;
      end
    end
  end

  assign head  = head_q;
  assign count = cnt_q;
endmodule

// File: rtl/stbuf_fwd.sv
module stbuf_fwd #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned PTR_W = $clog2(DEPTH)
) (
  input  logic [ADDR_W-1:0] slot_addr [DEPTH],
  input  logic [DATA_W-1:0] slot_data [DEPTH],
  input  logic [BE_W-1:0]   slot_be   [DEPTH],
  input  logic [PTR_W-1:0]  head,
  input  logic [PTR_W:0]    count,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              hit,
  output logic              conflict,
  output logic [DATA_W-1:0] data
);
  logic             found;
  logic [PTR_W-1:0] sel;
  logic [PTR_W-1:0] idx;
  logic             full_cov;

  // Walk from oldest to youngest; a later match overrides an earlier one
  always_comb begin
    found = 1'b0;
    sel   = '0;
    idx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      idx = head + PTR_W'(i);
      if (((PTR_W+1)'(i) < count) && (slot_addr[idx] == ld_addr)) begin
        found = 1'b1;
        sel   = idx;
      end
    end
    full_cov = &slot_be[sel];
    hit      = found & full_cov;
    conflict = found & ~full_cov;
    data     = hit ? slot_data[sel] : '0;
  end
endmodule

// File: rtl/stbuf_ordered.sv
module stbuf_ordered #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned NEV   = stbuf_pkg::NUM_SYNC_EV
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [DATA_W-1:0] st_data,
  input  logic [BE_W-1:0]   st_be,
  output logic              mem_valid,
  input  logic              mem_ready,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_data,
  output logic [BE_W-1:0]   mem_be,
  input  logic [NEV-1:0]    sync_ev,
  output logic              drain_done,
  output logic              buf_empty,
  input  logic [ADDR_W-1:0] ld_addr,
  output logic              ld_hit,
  output logic              ld_conflict,
  output logic [DATA_W-1:0] ld_data
);
  logic [ADDR_W-1:0] slot_addr [DEPTH];
  logic [DATA_W-1:0] slot_data [DEPTH];
  logic [BE_W-1:0]   slot_be   [DEPTH];
  logic [PTR_W-1:0]  head;
  logic [PTR_W:0]    occ;
  logic              push, pop, full, drain_active;

  assign full      = (occ == (PTR_W+1)'(DEPTH));
  assign buf_empty = (occ == '0);
  assign mem_valid = ~buf_empty;
  assign st_ready  = ~drain_active & (~full | mem_ready);
  assign push      = st_valid & st_ready;
  assign pop       = mem_valid & mem_ready;

  stbuf_ring #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst_n(rst_n), .push(push), .pop(pop),
    .in_addr(st_addr), .in_data(st_data), .in_be(st_be),
    .slot_addr(slot_addr), .slot_data(slot_data), .slot_be(slot_be),
    .head(head), .count(occ)
  );

  assign mem_addr = slot_addr[head];
  assign mem_data = slot_data[head];
  assign mem_be   = slot_be[head];

  stbuf_drain_ctl #(.NUM_EV(NEV)) u_drain (
    .clk(clk), .rst_n(rst_n), .sync_ev(sync_ev), .empty(buf_empty),
    .active(drain_active), .done(drain_done)
  );

  stbuf_fwd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_fwd (
    .slot_addr(slot_addr), .slot_data(slot_data), .slot_be(slot_be),
    .head(head), .count(occ), .ld_addr(ld_addr),
    .hit(ld_hit), .conflict(ld_conflict), .data(ld_data)
  );
endmodule

// File: rtl/stbuf_ordered_chk.sv
module stbuf_ordered_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned DEPTH  = 8,
  localparam int unsigned BE_W  = DATA_W / 8,
  localparam int unsigned PTR_W = $clog2(DEPTH),
  localparam int unsigned NEV   = stbuf_pkg::NUM_SYNC_EV
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_ready,
  input logic              mem_valid,
  input logic              mem_ready,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_data,
  input logic [BE_W-1:0]   mem_be,
  input logic [NEV-1:0]    sync_ev,
  input logic              drain_done,
  input logic              buf_empty,
  input logic              ld_hit,
  input logic              ld_conflict,
  input logic [PTR_W:0]    occ
);
  p_accept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_ready && !(mem_valid && mem_ready)) |=> !buf_empty);

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=> (mem_valid && $stable(mem_addr) &&
                                   $stable(mem_data) && $stable(mem_be)));

  p_full_stall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((occ == (PTR_W+1)'(DEPTH)) && !mem_ready) |-> !st_ready);

  p_no_overflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    st_ready |-> (occ <= (PTR_W+1)'(DEPTH)));

  p_drain_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (|sync_ev) |=> !st_ready);

  p_done_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    drain_done |-> (buf_empty && !mem_valid));

  p_empty_after_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(buf_empty) |-> $past(mem_valid && mem_ready));

  p_fwd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(ld_hit && ld_conflict));

  p_fwd_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
    buf_empty |-> (!ld_hit && !ld_conflict));
endmodule

bind stbuf_ordered stbuf_ordered_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
  .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
  .mem_data(mem_data), .mem_be(mem_be), .sync_ev(sync_ev),
  .drain_done(drain_done), .buf_empty(buf_empty), .ld_hit(ld_hit),
  .ld_conflict(ld_conflict), .occ(occ)
);

// File: tb/stbuf_ordered_bench.sv
module stbuf_ordered_bench;
  localparam int AW = 32;
  localparam int DW = 32;
  localparam int BW = DW / 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          st_valid;
  logic          st_ready;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic [BW-1:0] st_be;
  logic          mem_valid;
  logic          mem_ready;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_data;
  logic [BW-1:0] mem_be;
  logic [5:0]    sync_ev;
  logic          drain_done;
  logic          buf_empty;
  logic [AW-1:0] ld_addr;
  logic          ld_hit;
  logic          ld_conflict;
  logic [DW-1:0] ld_data;

  always #10 clk = ~clk;  // 50 MHz

  stbuf_ordered #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(8)) u_stbuf_ordered (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready),
    .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
    .mem_valid(mem_valid), .mem_ready(mem_ready), .mem_addr(mem_addr),
    .mem_data(mem_data), .mem_be(mem_be), .sync_ev(sync_ev),
    .drain_done(drain_done), .buf_empty(buf_empty), .ld_addr(ld_addr),
    .ld_hit(ld_hit), .ld_conflict(ld_conflict), .ld_data(ld_data)
  );

  int n_checks = 0;
  int n_fail   = 0;
  int sink_mode = 0;  // 0 stall, 1 always ready, 2 pattern
  logic [AW+DW+BW-1:0] exp_q [$];

  task automatic check(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Memory sink: only driver of mem_ready, changes just after each edge
  int sink_cyc = 0;
  always @(posedge clk) begin
    #1;
    sink_cyc++;
    case (sink_mode)
      0:       mem_ready = 1'b0;
      1:       mem_ready = 1'b1;
      default: mem_ready = sink_cyc[0] ^ sink_cyc[2];
    endcase
  end

  // Monitor: handshake values are settled at the falling edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (mem_valid && mem_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R2 unexpected write", 64'(mem_addr), 64'h0);
        end else begin
          logic [AW+DW+BW-1:0] e;
          e = exp_q.pop_front();
          check({mem_addr, mem_data, mem_be} == e, "R2 order/content",
                64'({mem_addr, mem_data}), 64'(e >> BW));
        end
      end
      if (drain_done && !buf_empty)
        check(1'b0, "R6 done while entries remain", 64'(buf_empty), 64'h1);
    end
  end

  task automatic do_store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                          input logic [BW-1:0] b);
    @(posedge clk); #1;
    st_valid = 1'b1; st_addr = a; st_data = d; st_be = b;
    @(negedge clk);
    while (!st_ready) @(negedge clk);
    exp_q.push_back({a, d, b});
    @(posedge clk); #1;
    st_valid = 1'b0;
  endtask

  task automatic wait_empty();
    for (int i = 0; i < 400 && !buf_empty; i++) @(negedge clk);
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0; st_be = '0;
    sync_ev = '0; ld_addr = 32'h0000_0200; mem_ready = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    // R11 reset state, R7 empty flag
    check(buf_empty == 1'b1, "R11 empty", 64'(buf_empty), 64'h1);
    check(mem_valid == 1'b0, "R7 mem_valid", 64'(mem_valid), 64'h0);
    check(st_ready == 1'b1, "R11 st_ready", 64'(st_ready), 64'h1);
    check(drain_done == 1'b0, "R11 drain_done", 64'(drain_done), 64'h0);

    // Fill to depth with memory stalled (R1)
    sink_mode = 0;
    do_store(32'h100, 32'h1111_1111, 4'hF);
    do_store(32'h104, 32'hBBBB_BBBB, 4'h3);
    do_store(32'h108, 32'hCCCC_CCCC, 4'hF);
    do_store(32'h100, 32'h2222_2222, 4'hF);
    for (int i = 0; i < 4; i++) do_store(32'h10C + 32'(4*i), 32'hF000_0000 + 32'(i), 4'hF);
    @(negedge clk);
    check(st_ready == 1'b0, "R4 full stall", 64'(st_ready), 64'h0);
    check(buf_empty == 1'b0, "R7 not empty", 64'(buf_empty), 64'h0);

    // Forwarding while frozen
    @(posedge clk); #1 ld_addr = 32'h100;
    @(negedge clk);
    check(ld_hit && ld_data == 32'h2222_2222, "R8 youngest hit", 64'(ld_data), 64'h2222_2222);
    @(posedge clk); #1 ld_addr = 32'h108;
    @(negedge clk);
    check(ld_hit && ld_data == 32'hCCCC_CCCC, "R8 hit single", 64'(ld_data), 64'hCCCC_CCCC);
    @(posedge clk); #1 ld_addr = 32'h104;
    @(negedge clk);
    check(ld_conflict && !ld_hit, "R9 partial conflict", 64'({ld_hit, ld_conflict}), 64'h1);
    @(posedge clk); #1 ld_addr = 32'h200;
    @(negedge clk);
    check(!ld_conflict && !ld_hit, "R10 miss", 64'({ld_hit, ld_conflict}), 64'h0);

    // Push and pop together at full occupancy (R4)
    sink_mode = 1;
    @(posedge clk); #1;
    st_valid = 1'b1; st_addr = 32'h300; st_data = 32'h9999_0000; st_be = 4'hF;
    @(negedge clk);
    check(st_ready == 1'b1, "R4 push with pop at full", 64'(st_ready), 64'h1);
    exp_q.push_back({32'h300, 32'h9999_0000, 4'hF});
    @(posedge clk); #1 st_valid = 1'b0;
    wait_empty();
    @(negedge clk);
    check(exp_q.size() == 0, "R2 all delivered", 64'(exp_q.size()), 64'h0);

    // Irregular back-pressure stream (R3, R2)
    sink_mode = 2;
    for (int i = 0; i < 20; i++)
      do_store(32'h400 + 32'(4*(i%5)), 32'hA500_0000 + 32'(i), 4'(i+1));
    wait_empty();
    @(negedge clk);
    check(exp_q.size() == 0, "R3 no drop under back-pressure", 64'(exp_q.size()), 64'h0);

    // Each drain trigger (R5, R6)
    for (int k = 0; k < 6; k++) begin
      sink_mode = 0;
      for (int j = 0; j < 3; j++) do_store(32'h500 + 32'(4*j), 32'(k*16+j), 4'hF);
      @(posedge clk); #1 sync_ev = 6'(1 << k);
      @(posedge clk); #1 sync_ev = '0;
      @(negedge clk);
      check(st_ready == 1'b0, "R5 store refused in drain", 64'(st_ready), 64'h0);
      check(drain_done == 1'b0, "R6 no early done", 64'(drain_done), 64'h0);
      sink_mode = 1;
      for (int i = 0; i < 50 && !drain_done; i++) @(negedge clk);
      check(drain_done && buf_empty, "R6 done after empty", 64'({drain_done, buf_empty}), 64'h3);
      check(exp_q.size() == 0, "R6 all older stores accepted", 64'(exp_q.size()), 64'h0);
      @(negedge clk);
      check(st_ready == 1'b1 && !drain_done, "R5 drain released", 64'(st_ready), 64'h1);
    end

    // Drain request on an empty buffer (R6)
    @(posedge clk); #1 sync_ev = 6'b000100;
    @(posedge clk); #1 sync_ev = '0;
    @(negedge clk);
    check(drain_done == 1'b1, "R6 empty drain completes", 64'(drain_done), 64'h1);
    check(st_ready == 1'b0, "R5 refused in empty drain", 64'(st_ready), 64'h0);
    @(negedge clk);
    check(st_ready == 1'b1, "R1 ready after drain", 64'(st_ready), 64'h1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule